// File: doc/BRIEF.md
# Halfword and Signed-Byte Load/Store Address Unit

This unit serves the execute stage of a 32-bit load/store core. It takes the instruction word of a halfword or signed-byte transfer along with the base register value, the offset register value and the value to store. It works out three things in the same cycle: the effective memory address, the updated base register value and the access attributes. Loads use a combinational memory port, so read data comes back in the cycle the command is accepted. In that cycle the unit extends the data to the full register width.

Commands arrive on a valid/ready channel. The only back-pressure comes from the register write side: `cmd_ready` follows `out_ready`. A command transfers, and the memory access takes place, only in a cycle where `cmd_valid` and `cmd_ready` are both high. Each accepted command yields registered write-back results in the following cycle. These are a base update pulse and a load result pulse, each one cycle wide. Downstream logic must take them in that cycle, and it keeps `out_ready` low for any cycle in which it cannot.

Top module: `misc_ls_agu`

## Requirements
- R1: When instruction bit 22 is 1, the offset is an 8-bit unsigned immediate. Its high nibble is instruction bits 11:8 and its low nibble is instruction bits 3:0.
- R2: When instruction bit 22 is 0, the offset is `cmd_ofs`, taken as a full-width value.
- R3: Instruction bit 23 set adds the offset to `cmd_base` and clear subtracts it. The arithmetic is modulo 2^32.
- R4: When bit 24 is 0, `mem_addr` equals `cmd_base` unchanged. One cycle after acceptance, `wb_en` is high and `wb_val` holds base plus or minus the offset.
- R5: When bit 24 is 1 and bit 21 is 0, `mem_addr` is base plus or minus the offset, and `wb_en` stays low in the following cycle.
- R6: When bits 24 and 21 are both 1, `mem_addr` is base plus or minus the offset. In the following cycle `wb_en` is high and `wb_val` equals that address.
- R7: When bit 24 is 0, the unit ignores bit 21. Encodings with bit 21 set give the same address and write-back as the same encoding with bit 21 clear.
- R8: A load has bit 20 = 1. If bits 6:5 are 01 or 00, the load result is the low 16 bits of `mem_rdata` with the upper bits set to zero.
- R9: A load with bits 6:5 = 10 is a byte access (`mem_byte` high). Its result is `mem_rdata[7:0]` with bit 7 copied into every upper bit.
- R10: A load with bits 6:5 = 11 gives `mem_rdata[15:0]` with bit 15 copied into every upper bit.
- R11: A store has bit 20 = 0. It asserts `mem_we`, drives `mem_wdata` with `cmd_store_val[15:0]` and produces no load result.
- R12: `cmd_ready` equals `out_ready`. `wb_en` and `ld_valid` are high only in the cycle right after an accepted command. `wb_reg` is instruction bits 19:16 and `ld_reg` is bits 15:12.
- R13: A load that writes back its base loses the base update when bits 15:12 equal bits 19:16. In that case `wb_en` stays low and only the load result is written.
- R14: While `rst_n` is low and after it is released, `wb_en` and `ld_valid` are low until a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_instr | input | 32 | Instruction word |
| cmd_base | input | XLEN | Base register value |
| cmd_ofs | input | XLEN | Offset register value |
| cmd_store_val | input | XLEN | Register value to store |
| out_ready | input | 1 | Register write side can take results next cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a store |
| mem_byte | output | 1 | Access is one byte (else halfword) |
| mem_addr | output | XLEN | Effective address |
| mem_wdata | output | 16 | Halfword to store |
| mem_rdata | input | XLEN | Read data, valid in the accepting cycle |
| wb_en | output | 1 | Base register update pulse |
| wb_reg | output | 4 | Base register index |
| wb_val | output | XLEN | Updated base value |
| ld_valid | output | 1 | Load result pulse |
| ld_reg | output | 4 | Destination register index |
| ld_data | output | XLEN | Extended load result |

## Verification
The bench runs all sixteen settings of bits 24:21 with both an immediate and a register offset. A decoder that swapped the roles of bits 24 and 21 would put an offset on a post-indexed access, or skip the base update on a pre-indexed one. Subtractions that borrow below zero and additions that carry past the top are included, so a unit that did not truncate to 32 bits, or that read the offset as signed, produces wrong addresses. Byte and halfword values with the sign bit set and clear, together with the equal-register load case, catch a wrong sign source bit and a base update that overrides the loaded value.

// File: rtl/misc_ls_pkg.sv
package misc_ls_pkg;

  typedef enum logic [1:0] {
    EXT_UHALF = 2'd0,
    EXT_SBYTE = 2'd1,
    EXT_SHALF = 2'd2
  } ext_kind_e;

  typedef struct packed {
    logic       pre;
    logic       up;
    logic       use_imm;
    logic       wr_back;
    logic       load;
    logic [3:0] rn;
    logic [3:0] rd;
    logic [1:0] sh;
    logic [7:0] imm8;
  } ls_fields_t;

  function automatic ls_fields_t split_fields(input logic [31:0] w);
    ls_fields_t f;
    f.pre     = w[24];
    f.up      = w[23];
    f.use_imm = w[22];
    f.wr_back = w[21];
    f.load    = w[20];
    f.rn      = w[19:16];
    f.rd      = w[15:12];
    f.sh      = w[6:5];
    f.imm8    = {w[11:8], w[3:0]};
    return f;
  endfunction

  function automatic ext_kind_e kind_of(input logic [1:0] sh);
    case (sh)
      2'b10:   return EXT_SBYTE;
      2'b11:   return EXT_SHALF;
      default: return EXT_UHALF;
    endcase
  endfunction

endpackage

// File: rtl/misc_ls_offset.sv
module misc_ls_offset #(
  parameter int XLEN = 32
) (
  input  logic            use_imm,
  input  logic [7:0]      imm8,
  input  logic [XLEN-1:0] reg_ofs,
  output logic [XLEN-1:0] off
);
  localparam int PAD = XLEN - 8;

  always_comb begin
    if (use_imm) off = {{PAD{1'b0}}, imm8};
    else         off = reg_ofs;
  end
endmodule

// File: rtl/misc_ls_addr.sv
module misc_ls_addr #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] off,
  input  logic            up,
  input  logic            pre,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] next_base
);
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;

  assign sum  = base + off;
  assign diff = base - off;

  always_comb begin
    next_base = up ? sum : diff;
    addr      = pre ? next_base : base;
  end
endmodule

// File: rtl/misc_ls_extend.sv
module misc_ls_extend
  import misc_ls_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ext_kind_e       kind,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] ext
);
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;
  localparam int HI_H   = XLEN - HALF_W;
  localparam int HI_B   = XLEN - BYTE_W;

  logic unused_hi;
  assign unused_hi = ^raw[XLEN-1:HALF_W];

  always_comb begin
    case (kind)
      EXT_SBYTE: ext = {{HI_B{raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
      EXT_SHALF: ext = {{HI_H{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
      default:   ext = {{HI_H{1'b0}}, raw[HALF_W-1:0]};
    endcase
  end
endmodule

// File: rtl/misc_ls_agu.sv
module misc_ls_agu
  import misc_ls_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [31:0]     cmd_instr,
  input  logic [XLEN-1:0] cmd_base,
  input  logic [XLEN-1:0] cmd_ofs,
  input  logic [XLEN-1:0] cmd_store_val,
  input  logic            out_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_byte,
  output logic [XLEN-1:0] mem_addr,
  output logic [15:0]     mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            wb_en,
  output logic [3:0]      wb_reg,
  output logic [XLEN-1:0] wb_val,
  output logic            ld_valid,
  output logic [3:0]      ld_reg,
  output logic [XLEN-1:0] ld_data
);
  ls_fields_t      f;
  ext_kind_e       kind;
  logic [XLEN-1:0] off;
  logic [XLEN-1:0] next_base;
  logic [XLEN-1:0] ext;
  logic            fire;
  logic            base_upd;
  logic            clash;
  logic            unused_bits;

  assign f           = split_fields(cmd_instr);
  assign kind        = kind_of(f.sh);
  assign unused_bits = ^{cmd_instr[31:25], cmd_instr[7], cmd_instr[4],
                         cmd_store_val[XLEN-1:16]};

  misc_ls_offset #(.XLEN(XLEN)) u_ofs (
    .use_imm (f.use_imm),
    .imm8    (f.imm8),
    .reg_ofs (cmd_ofs),
    .off     (off)
  );

  misc_ls_addr #(.XLEN(XLEN)) u_addr (
    .base      (cmd_base),
    .off       (off),
    .up        (f.up),
    .pre       (f.pre),
    .addr      (mem_addr),
    .next_base (next_base)
  );

  misc_ls_extend #(.XLEN(XLEN)) u_ext (
    .kind (kind),
    .raw  (mem_rdata),
    .ext  (ext)
  );

  assign cmd_ready = out_ready;
  assign fire      = cmd_valid & out_ready;
  assign mem_req   = fire;
  assign mem_we    = ~f.load;
  assign mem_byte  = f.load & (kind == EXT_SBYTE);
  assign mem_wdata = cmd_store_val[15:0];

  // post-indexed always updates; pre-indexed only with the write-back bit
  assign base_upd = ~f.pre | f.wr_back;
  assign clash    = f.load & (f.rd == f.rn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en    <= 1'b0;
      ld_valid <= 1'b0;
    end else begin
      wb_en    <= fire & base_upd & ~clash;
      ld_valid <= fire & f.load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_reg  <= '0;
      wb_val  <= '0;
      ld_reg  <= '0;
      ld_data <= '0;
    end else if (fire) begin
      wb_reg  <= f.rn;
      wb_val  <= next_base;
      ld_reg  <= f.rd;
      ld_data <= ext;
    end
  end
endmodule

// File: rtl/misc_ls_agu_chk.sv
module misc_ls_agu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [31:0]     cmd_instr,
  input logic [XLEN-1:0] cmd_base,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_rdata,
  input logic            wb_en,
  input logic [XLEN-1:0] wb_val,
  input logic            ld_valid,
  input logic [XLEN-1:0] ld_data
);
  logic acc;
  logic same_reg_ld;
  assign acc         = cmd_valid & cmd_ready;
  assign same_reg_ld = cmd_instr[20] & (cmd_instr[15:12] == cmd_instr[19:16]);

  p_post_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmd_instr[24] |-> mem_addr == cmd_base);

  p_offset_nowb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_instr[24] && !cmd_instr[21] |=> !wb_en);

  p_pre_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_instr[24] && cmd_instr[21] && !same_reg_ld
    |=> wb_en && wb_val == $past(mem_addr));

  p_sbyte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_instr[20] && cmd_instr[6:5] == 2'b10
    |=> ld_data == {{(XLEN-8){$past(mem_rdata[7])}}, $past(mem_rdata[7:0])});

  p_shalf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_instr[20] && cmd_instr[6:5] == 2'b11
    |=> ld_data == {{(XLEN-16){$past(mem_rdata[15])}}, $past(mem_rdata[15:0])});

  p_idle_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !wb_en && !ld_valid);

  p_clash_r13: assert property (@(posedge clk) disable iff (!rst_n)
    acc && same_reg_ld && (!cmd_instr[24] || cmd_instr[21]) |=> !wb_en && ld_valid);
endmodule

bind misc_ls_agu misc_ls_agu_chk #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_instr (cmd_instr),
  .cmd_base  (cmd_base),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .wb_en     (wb_en),
  .wb_val    (wb_val),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data)
);

// File: tb/misc_ls_agu_tb_top.sv
`timescale 1ns/1ps
module misc_ls_agu_tb_top;
  localparam int XLEN = 32;

  typedef struct packed {
    logic [3:0]  mode;
    logic        l;
    logic [1:0]  sh;
    logic [7:0]  imm;
    logic [31:0] base;
    logic [31:0] ofs;
    logic [31:0] rdata;
    logic [31:0] exp_addr;
    logic        exp_wb;
    logic [31:0] exp_wbv;
    logic [31:0] exp_ld;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1000, 1'b1, 32'h0FE0, 32'h8001},
    '{4'd1,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1000, 1'b1, 32'h0FE0, 32'h8001},
    '{4'd2,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1000, 1'b1, 32'h0FA6, 32'h8001},
    '{4'd3,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1000, 1'b1, 32'h0FA6, 32'h8001},
    '{4'd4,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1000, 1'b1, 32'h1020, 32'h8001},
    '{4'd5,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1000, 1'b1, 32'h1020, 32'h8001},
    '{4'd6,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1000, 1'b1, 32'h105A, 32'h8001},
    '{4'd7,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1000, 1'b1, 32'h105A, 32'h8001},
    '{4'd8,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h0FE0, 1'b0, 32'h0,    32'h8001},
    '{4'd9,  1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h0FE0, 1'b1, 32'h0FE0, 32'h8001},
    '{4'd10, 1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h0FA6, 1'b0, 32'h0,    32'h8001},
    '{4'd11, 1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h0FA6, 1'b1, 32'h0FA6, 32'h8001},
    '{4'd12, 1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1020, 1'b0, 32'h0,    32'h8001},
    '{4'd13, 1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h1020, 1'b1, 32'h1020, 32'h8001},
    '{4'd14, 1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h105A, 1'b0, 32'h0,    32'h8001},
    '{4'd15, 1'b1, 2'b01, 8'h5A, 32'h1000, 32'h20, 32'h8001, 32'h105A, 1'b1, 32'h105A, 32'h8001},
    '{4'd10, 1'b1, 2'b01, 8'h5A, 32'h10,       32'h0,        32'h1234, 32'hFFFFFFB6, 1'b0, 32'h0,  32'h1234},
    '{4'd12, 1'b1, 2'b01, 8'h00, 32'hFFFFFFF0, 32'h20,       32'h1234, 32'h00000010, 1'b0, 32'h0,  32'h1234},
    '{4'd6,  1'b1, 2'b01, 8'h5A, 32'hFFFFFFC0, 32'h0,        32'h1234, 32'hFFFFFFC0, 1'b1, 32'h1A, 32'h1234},
    '{4'd8,  1'b1, 2'b01, 8'h00, 32'h100,      32'hFFFFFFFF, 32'h1234, 32'h00000101, 1'b0, 32'h0,  32'h1234},
    '{4'd14, 1'b1, 2'b10, 8'h01, 32'h300, 32'h0, 32'h12345680, 32'h301, 1'b0, 32'h0, 32'hFFFFFF80},
    '{4'd14, 1'b1, 2'b10, 8'h01, 32'h300, 32'h0, 32'h0000AB7F, 32'h301, 1'b0, 32'h0, 32'h0000007F},
    '{4'd14, 1'b1, 2'b11, 8'h01, 32'h300, 32'h0, 32'h00018000, 32'h301, 1'b0, 32'h0, 32'hFFFF8000},
    '{4'd14, 1'b1, 2'b11, 8'h01, 32'h300, 32'h0, 32'h00007FFF, 32'h301, 1'b0, 32'h0, 32'h00007FFF},
    '{4'd14, 1'b1, 2'b01, 8'h01, 32'h300, 32'h0, 32'hFFFFFFFF, 32'h301, 1'b0, 32'h0, 32'h0000FFFF},
    '{4'd15, 1'b0, 2'b01, 8'h04, 32'h200, 32'h0, 32'h0,        32'h204, 1'b1, 32'h204, 32'h0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [31:0]     cmd_instr = '0;
  logic [XLEN-1:0] cmd_base = '0;
  logic [XLEN-1:0] cmd_ofs = '0;
  logic [XLEN-1:0] cmd_store_val = 32'hCAFEBEEF;
  logic            out_ready = 1'b1;
  logic            mem_req;
  logic            mem_we;
  logic            mem_byte;
  logic [XLEN-1:0] mem_addr;
  logic [15:0]     mem_wdata;
  logic [XLEN-1:0] mem_rdata = '0;
  logic            wb_en;
  logic [3:0]      wb_reg;
  logic [XLEN-1:0] wb_val;
  logic            ld_valid;
  logic [3:0]      ld_reg;
  logic [XLEN-1:0] ld_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  misc_ls_agu #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_instr(cmd_instr), .cmd_base(cmd_base), .cmd_ofs(cmd_ofs),
    .cmd_store_val(cmd_store_val), .out_ready(out_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_val(wb_val), .ld_valid(ld_valid), .ld_reg(ld_reg),
    .ld_data(ld_data)
  );

  function automatic logic [31:0] mk(input logic [3:0] mode, input logic l,
                                     input logic [3:0] rn, input logic [3:0] rd,
                                     input logic [7:0] imm, input logic [1:0] sh);
    return {4'hE, 3'b000, mode, l, rn, rd, imm[7:4], 1'b1, sh, 1'b1, imm[3:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ins, input logic [31:0] b,
                       input logic [31:0] o, input logic [31:0] rd);
    cmd_valid = 1'b1;
    cmd_instr = ins;
    cmd_base  = b;
    cmd_ofs   = o;
    mem_rdata = rd;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wb_en && !ld_valid, "R14 in reset", {wb_en, ld_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wb_en && !ld_valid, "R14 after reset", {wb_en, ld_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      string at, wt;
      vec_t v;
      v = VECS[i];
      if (i < 16)      at = v.mode[1] ? "R1 imm addr" : "R2 reg addr";
      else if (i < 20) at = "R3 wrap addr";
      else if (i < 25) at = "R5 ext addr";
      else             at = "R11 store addr";
      if (!v.mode[3])      wt = v.mode[0] ? "R7 post wb" : "R4 post wb";
      else if (!v.mode[0]) wt = "R5 no wb";
      else                 wt = "R6 pre wb";
      @(negedge clk);
      drive(mk(v.mode, v.l, 4'd1, 4'd2, v.imm, v.sh), v.base, v.ofs, v.rdata);
      #1;
      chk(mem_addr == v.exp_addr, at, mem_addr, v.exp_addr);
      chk(mem_req && mem_we == !v.l, "R11 dir", {mem_req, mem_we}, {1'b1, !v.l});
      chk(mem_byte == (v.l && v.sh == 2'b10), "R9 size", mem_byte, (v.l && v.sh == 2'b10));
      chk(mem_wdata == 16'hBEEF, "R11 wdata", mem_wdata, 16'hBEEF);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(wb_en == v.exp_wb, wt, wb_en, v.exp_wb);
      if (v.exp_wb) begin
        chk(wb_val == v.exp_wbv, wt, wb_val, v.exp_wbv);
        chk(wb_reg == 4'd1, "R12 wb_reg", wb_reg, 1);
      end
      chk(ld_valid == v.l, "R11 ld_valid", ld_valid, v.l);
      if (v.l) begin
        if (v.sh == 2'b10)      chk(ld_data == v.exp_ld, "R9 sbyte", ld_data, v.exp_ld);
        else if (v.sh == 2'b11) chk(ld_data == v.exp_ld, "R10 shalf", ld_data, v.exp_ld);
        else                    chk(ld_data == v.exp_ld, "R8 uhalf", ld_data, v.exp_ld);
        chk(ld_reg == 4'd2, "R12 ld_reg", ld_reg, 2);
      end
    end

    // pulses last one cycle
    @(negedge clk);
    chk(!wb_en && !ld_valid, "R12 single pulse", {wb_en, ld_valid}, 0);

    // back-pressure: nothing accepted while out_ready is low
    out_ready = 1'b0;
    drive(mk(4'd13, 1'b1, 4'd1, 4'd2, 8'h00, 2'b01), 32'h40, 32'h4, 32'h0);
    #1;
    chk(!cmd_ready && !mem_req, "R12 stall", {cmd_ready, mem_req}, 0);
    @(negedge clk);
    chk(!wb_en && !ld_valid, "R12 stall no pulse", {wb_en, ld_valid}, 0);
    out_ready = 1'b1;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(!wb_en && !ld_valid, "R12 idle", {wb_en, ld_valid}, 0);

    // load with base write-back into the same register
    drive(mk(4'd13, 1'b1, 4'd3, 4'd3, 8'h00, 2'b11), 32'h80, 32'h8, 32'h0000F00D);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!wb_en, "R13 base dropped", wb_en, 0);
    chk(ld_valid && ld_reg == 4'd3, "R13 load kept", {ld_valid, ld_reg}, {1'b1, 4'd3});
    chk(ld_data == 32'hFFFFF00D, "R13 data", ld_data, 32'hFFFFF00D);

    // post-indexed load into same register also drops base update
    drive(mk(4'd4, 1'b1, 4'd5, 4'd5, 8'h00, 2'b01), 32'h80, 32'h8, 32'h1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!wb_en && ld_valid, "R13 post", {wb_en, ld_valid}, {1'b0, 1'b1});

    // a store into the same register keeps its base update
    drive(mk(4'd13, 1'b0, 4'd3, 4'd3, 8'h00, 2'b01), 32'h80, 32'h8, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(wb_en && wb_val == 32'h88, "R13 store keeps wb", wb_val, 32'h88);
    chk(!ld_valid, "R11 store no load", ld_valid, 0);

    // back-to-back accepts each give a pulse
    drive(mk(4'd6, 1'b1, 4'd1, 4'd2, 8'h10, 2'b01), 32'h100, 32'h0, 32'h0);
    @(negedge clk);
    chk(wb_en && wb_val == 32'h110, "R4 first", wb_val, 32'h110);
    drive(mk(4'd2, 1'b1, 4'd1, 4'd2, 8'h10, 2'b01), 32'h100, 32'h0, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(wb_en && wb_val == 32'hF0, "R4 second", wb_val, 32'hF0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule